// File: doc/BRIEF.md
# Bus Data-Phase Beat Sequencer

This block runs the data phase of a bus master whose 64-bit data path is divided into eight byte lanes. A requester hands it one transfer: its direction, its size, a byte offset, a burst flag, the width of the target port and, for writes, the whole payload. The block then raises its bus-busy output and steps through the data beats. For writes it drives the data bus and its output enable. For reads it captures the incoming data and gives each captured piece to the requester, tagged with the beat and sub-beat it belongs to.

Two strobes from the slave move the sequence on. A full acknowledge closes the current 64-bit beat. A partial data-valid moves to the next port-width chunk inside that beat, which is how a narrow port splits a wide transfer. Write data is copied across the lanes so that an 8-, 16- or 32-bit port always sees the chosen bytes on the lanes it is wired to. The bus is released one cycle after the final acknowledge, an error or a retry. The block then reports done, error or retry with a single-cycle pulse.

Top module: `bus_beat_seq`

## Requirements
- R1: While reset is asserted, and after it is released, bus_busy_o, bus_data_oe_o, xfer_done_o, xfer_err_o, xfer_retry_o and rd_valid_o are 0.
- R2: A req_start seen while idle is accepted at that clock edge. From the next cycle bus_busy_o is 1. For a write (req_write=1), bus_data_oe_o is 1 and beat 0 is on the bus in that same cycle. For a read, bus_data_oe_o stays 0.
- R3: A burst (req_burst=1) has four 64-bit beats, taken from req_wdata bits [64b+63:64b] for beat b. Each ack_i moves to the next beat in the following cycle.
- R4: part_ack_i without ack_i moves to the next port-width chunk of the same beat in the following cycle. The chunk's byte address advances by the port width, modulo 8.
- R5: Lane k is bus bits [8k+7:8k]. req_port selects the port width: 0=8, 1=16, 2=32, 3=64 bits, so the port is P = 1<<req_port bytes wide. For each lane k, the driven byte is the byte at lane A + (k mod P) of the beat word, where A is the current chunk address rounded down to a multiple of P.
- R6: A single-beat transfer (req_burst=0) covers 1<<req_size bytes (req_size 0..3 = 1, 2, 4, 8 bytes). Its first chunk starts at req_offset rounded down to the transfer size.
- R7: After the ack_i that closes the last beat, the next cycle has bus_busy_o=0 and bus_data_oe_o=0, and xfer_done_o is 1 for exactly one cycle.
- R8: err_i during a transfer ends it in the next cycle with a one-cycle xfer_err_o. It wins over ack_i in the same cycle: no xfer_done_o, no captured read beat, and the bus is released.
- R9: retry_i during a transfer without err_i ends it in the next cycle with a one-cycle xfer_retry_o. It wins over ack_i: no xfer_done_o and no captured read beat.
- R10: On a read, bus_data_i is sampled in the cycle that ack_i or part_ack_i is high. In the next cycle rd_valid_o=1, and rd_data_o, rd_beat_o and rd_sub_o give the data and its beat and sub-beat index.
- R11: req_start while a transfer is in progress is ignored. The bus data, enable and beat sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_start | input | 1 | Start a transfer (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = four-beat burst |
| req_size | input | 2 | Single-beat size code: 1, 2, 4, 8 bytes |
| req_offset | input | 3 | Byte offset of a single-beat transfer |
| req_port | input | 2 | Port width code: 8, 16, 32, 64 bits |
| req_wdata | input | 256 | Write payload, beat b in bits [64b+63:64b] |
| bus_busy_o | output | 1 | Data bus busy |
| bus_data_o | output | 64 | Write data on the bus |
| bus_data_oe_o | output | 1 | Data bus output enable |
| bus_data_i | input | 64 | Read data from the bus |
| ack_i | input | 1 | Full transfer acknowledge |
| part_ack_i | input | 1 | Partial port-size data-valid |
| err_i | input | 1 | Transfer error |
| retry_i | input | 1 | Retry, ends the data phase |
| rd_valid_o | output | 1 | Captured read data valid |
| rd_data_o | output | 64 | Captured read data |
| rd_beat_o | output | 2 | Beat index of captured data |
| rd_sub_o | output | 3 | Sub-beat index of captured data |
| xfer_done_o | output | 1 | Transfer completed pulse |
| xfer_err_o | output | 1 | Transfer aborted by error pulse |
| xfer_retry_o | output | 1 | Transfer aborted by retry pulse |

## Verification
The acknowledge that would finish or advance a transfer can arrive in the same cycle as an error or a retry. The bench forces this on purpose. It raises ack_i together with err_i, and ack_i together with retry_i, at the second beat of both write and read bursts. It then checks the next cycle: the bus must be released, only the abort pulse may appear, xfer_done_o must stay low and no read beat may be presented. A second overlap, a new request arriving in the middle of a burst, is checked by watching that the driven beat and the enable do not move.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {PORT_B8, PORT_B16, PORT_B32, PORT_B64} port_e;
  typedef enum logic {ST_IDLE, ST_ACT} state_e;
endpackage

// File: rtl/bbs_ctrl.sv
module bbs_ctrl #(
  parameter int LANES = 8,
  parameter int BEATS = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              st_wr,
  input  logic              st_burst,
  input  logic [1:0]        st_size,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [1:0]        st_port,
  input  logic              ack,
  input  logic              part_ack,
  input  logic              err,
  input  logic              retry,
  output logic              accept,
  output logic              active,
  output logic              wr_mode,
  output logic [BEAT_W-1:0] beat,
  output logic [OFF_W-1:0]  sub,
  output logic [OFF_W-1:0]  lane_base,
  output logic [OFF_W-1:0]  pb_mask,
  output logic              done,
  output logic              err_p,
  output logic              retry_p
);
  import bbs_pkg::*;

  localparam logic [BEAT_W-1:0] LAST_BURST = BEAT_W'(BEATS - 1);

  state_e            state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [OFF_W-1:0]  sub_q, sub_d;
  logic              done_q, done_d, err_q, err_d, retry_q, retry_d;
  logic              cfg_en;
  logic              wr_q, burst_q;
  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;
  port_e             port_q;
  logic [BEAT_W-1:0] last_beat;
  logic [OFF_W-1:0]  sz_mask, base, addr;

  assign last_beat = burst_q ? LAST_BURST : '0;

  // next-state process
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    sub_d   = sub_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    retry_d = 1'b0;
    cfg_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_ACT;
          beat_d  = '0;
          sub_d   = '0;
          cfg_en  = 1'b1;
        end
      end
      ST_ACT: begin
        if (err) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (retry) begin
          state_d = ST_IDLE;
          retry_d = 1'b1;
        end else if (ack) begin
          if (beat_q == last_beat) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            beat_d = beat_q + 1'b1;
            sub_d  = '0;
          end
        end else if (part_ack) begin
          sub_d = sub_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      sub_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      sub_q   <= sub_d;
      done_q  <= done_d;
      err_q   <= err_d;
      retry_q <= retry_d;
    end
  end

  // configuration registers, loaded on accept only
  always_ff @(posedge clk) begin
    if (cfg_en) begin
      wr_q    <= st_wr;
      burst_q <= st_burst;
      size_q  <= st_size;
      off_q   <= st_off;
      port_q  <= port_e'(st_port);
    end
  end

  // chunk address of the current sub-beat
  always_comb begin
    sz_mask   = OFF_W'((1 << size_q) - 1);
    pb_mask   = OFF_W'((1 << port_q) - 1);
    base      = burst_q ? '0 : (off_q & ~sz_mask);
    addr      = base + (sub_q << port_q);
    lane_base = addr & ~pb_mask;
  end

  assign accept  = cfg_en;
  assign active  = (state_q == ST_ACT);
  assign wr_mode = wr_q;
  assign beat    = beat_q;
  assign sub     = sub_q;
  assign done    = done_q;
  assign err_p   = err_q;
  assign retry_p = retry_q;

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start) && beat_q == '0 && sub_q == '0);
  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && ack && !err && !retry && beat_q != last_beat |=> active && beat_q == $past(beat_q) + 1'b1);
  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !active && !err_q && !retry_q);
  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && err |=> !active && err_q && !done_q);
  // R9
  retry_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && retry && !err |=> !active && retry_q && !done_q);
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && start && !ack && !part_ack && !err && !retry |=> active && $stable(beat_q) && $stable(sub_q));
endmodule

// File: rtl/bbs_lane_mux.sv
module bbs_lane_mux #(
  parameter int LANES = 8,
  localparam int DW = LANES * 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DW-1:0]    word,
  input  logic [OFF_W-1:0] lane_base,
  input  logic [OFF_W-1:0] pb_mask,
  output logic [DW-1:0]    lanes_out
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [OFF_W-1:0] KIDX = OFF_W'(k);
    logic [OFF_W-1:0] src;
    always_comb begin
      src = lane_base | (KIDX & pb_mask);
      lanes_out[8*k +: 8] = word[8*src +: 8];
    end
  end
endmodule

// File: rtl/bbs_rd_capture.sv
module bbs_rd_capture #(
  parameter int LANES = 8,
  parameter int BEATS = 4,
  localparam int DW = LANES * 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DW-1:0]     d_in,
  input  logic [BEAT_W-1:0] beat,
  input  logic [OFF_W-1:0]  sub,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [BEAT_W-1:0] rd_beat,
  output logic [OFF_W-1:0]  rd_sub
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= cap_en;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      rd_data <= d_in;
      rd_beat <= beat;
      rd_sub  <= sub;
    end
  end
endmodule

// File: rtl/bus_beat_seq.sv
module bus_beat_seq #(
  parameter int LANES = 8,
  parameter int BEATS = 4,
  localparam int DW = LANES * 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_start,
  input  logic                req_write,
  input  logic                req_burst,
  input  logic [1:0]          req_size,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [1:0]          req_port,
  input  logic [BEATS*DW-1:0] req_wdata,
  output logic                bus_busy_o,
  output logic [DW-1:0]       bus_data_o,
  output logic                bus_data_oe_o,
  input  logic [DW-1:0]       bus_data_i,
  input  logic                ack_i,
  input  logic                part_ack_i,
  input  logic                err_i,
  input  logic                retry_i,
  output logic                rd_valid_o,
  output logic [DW-1:0]       rd_data_o,
  output logic [BEAT_W-1:0]   rd_beat_o,
  output logic [OFF_W-1:0]    rd_sub_o,
  output logic                xfer_done_o,
  output logic                xfer_err_o,
  output logic                xfer_retry_o
);
  logic [1:0]          rst_sync;
  logic                rst_n_s;
  logic                accept, active, wr_mode;
  logic [BEAT_W-1:0]   beat;
  logic [OFF_W-1:0]    sub, lane_base, pb_mask;
  logic [BEATS*DW-1:0] wdata_q;
  logic [DW-1:0]       beat_word, lanes_out;
  logic                cap_en;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  bbs_ctrl #(.LANES(LANES), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .start(req_start), .st_wr(req_write), .st_burst(req_burst),
    .st_size(req_size), .st_off(req_offset), .st_port(req_port),
    .ack(ack_i), .part_ack(part_ack_i), .err(err_i), .retry(retry_i),
    .accept(accept), .active(active), .wr_mode(wr_mode),
    .beat(beat), .sub(sub), .lane_base(lane_base), .pb_mask(pb_mask),
    .done(xfer_done_o), .err_p(xfer_err_o), .retry_p(xfer_retry_o)
  );

  // payload store, loaded on accept
  always_ff @(posedge clk) begin
    if (accept) wdata_q <= req_wdata;
  end

  assign beat_word = wdata_q[beat*DW +: DW];

  bbs_lane_mux #(.LANES(LANES)) u_mux (
    .word(beat_word), .lane_base(lane_base), .pb_mask(pb_mask), .lanes_out(lanes_out)
  );

  assign cap_en = active && !wr_mode && (ack_i || part_ack_i) && !err_i && !retry_i;

  bbs_rd_capture #(.LANES(LANES), .BEATS(BEATS)) u_cap (
    .clk(clk), .rst_n(rst_n_s), .cap_en(cap_en), .d_in(bus_data_i),
    .beat(beat), .sub(sub),
    .rd_valid(rd_valid_o), .rd_data(rd_data_o), .rd_beat(rd_beat_o), .rd_sub(rd_sub_o)
  );

  assign bus_busy_o    = active;
  assign bus_data_oe_o = active && wr_mode;
  assign bus_data_o    = bus_data_oe_o ? lanes_out : '0;

  // R2
  oe_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_data_oe_o |-> bus_busy_o);
  // R10
  rd_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_valid_o |-> $past(bus_busy_o) && !$past(bus_data_oe_o));
  // R8
  no_rd_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    xfer_err_o |-> !rd_valid_o && !xfer_done_o);
endmodule

// File: tb/bus_beat_seq_test.sv
module bus_beat_seq_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_start, req_write, req_burst;
  logic [1:0]   req_size, req_port;
  logic [2:0]   req_offset;
  logic [255:0] req_wdata;
  logic         bus_busy_o, bus_data_oe_o;
  logic [63:0]  bus_data_o, bus_data_i, rd_data_o;
  logic         ack_i, part_ack_i, err_i, retry_i;
  logic         rd_valid_o, xfer_done_o, xfer_err_o, xfer_retry_o;
  logic [1:0]   rd_beat_o;
  logic [2:0]   rd_sub_o;

  int checks = 0;
  int fails = 0;
  int tnum = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_beat_seq uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_burst(req_burst), .req_size(req_size), .req_offset(req_offset),
    .req_port(req_port), .req_wdata(req_wdata), .bus_busy_o(bus_busy_o),
    .bus_data_o(bus_data_o), .bus_data_oe_o(bus_data_oe_o), .bus_data_i(bus_data_i),
    .ack_i(ack_i), .part_ack_i(part_ack_i), .err_i(err_i), .retry_i(retry_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_beat_o(rd_beat_o),
    .rd_sub_o(rd_sub_o), .xfer_done_o(xfer_done_o), .xfer_err_o(xfer_err_o),
    .xfer_retry_o(xfer_retry_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input bit bu, input int sc, input int off, input int pc);
    tnum++;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++)
        req_wdata[b*64 + k*8 +: 8] = 8'(tnum*29 + b*53 + k*7 + 3);
    @(negedge clk);
    req_write = wr; req_burst = bu; req_size = 2'(sc);
    req_offset = 3'(off); req_port = 2'(pc); req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  function automatic logic [63:0] exp_word(input int b, input int a0, input int s, input int pb);
    logic [63:0] w;
    int a;
    a = (a0 + s*pb) % 8;
    a = a - (a % pb);
    for (int k = 0; k < 8; k++)
      w[k*8 +: 8] = req_wdata[b*64 + (a + k % pb)*8 +: 8];
    return w;
  endfunction

  task automatic do_write(input bit bu, input int sc, input int off, input int pc, input bit poke);
    int sz, pb, nb, nsub, a0;
    logic [63:0] e;
    string tag;
    sz = 1 << sc; pb = 1 << pc; nb = bu ? 4 : 1;
    nsub = bu ? 8/pb : (sz > pb ? sz/pb : 1);
    a0 = bu ? 0 : off - (off % sz);
    issue(1'b1, bu, sc, off, pc);
    chk("R2 busy/oe", {62'b0, bus_busy_o, bus_data_oe_o}, 64'd3);
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < nsub; s++) begin
        e = exp_word(b, a0, s, pb);
        if (s > 0) tag = "R4 sub-beat";
        else if (pc < 3) tag = "R5 replicate";
        else if (bu) tag = "R3 burst beat";
        else tag = "R6 single";
        chk(tag, bus_data_o, e);
        if (poke && b == 1 && s == 0) begin
          req_start = 1'b1; req_write = 1'b0; req_burst = 1'b0;
          @(negedge clk);
          req_start = 1'b0;
          chk("R11 data held", bus_data_o, e);
          chk("R11 oe held", {62'b0, bus_busy_o, bus_data_oe_o}, 64'd3);
        end
        if (s < nsub-1) part_ack_i = 1'b1; else ack_i = 1'b1;
        @(negedge clk);
        part_ack_i = 1'b0; ack_i = 1'b0;
      end
    end
    chk("R7 release", {61'b0, bus_busy_o, bus_data_oe_o, xfer_done_o}, 64'd1);
    @(negedge clk);
    chk("R7 done pulse", {63'b0, xfer_done_o}, 64'd0);
  endtask

  task automatic do_read(input bit bu, input int sc, input int off, input int pc);
    int sz, pb, nb, nsub;
    logic [63:0] v;
    sz = 1 << sc; pb = 1 << pc; nb = bu ? 4 : 1;
    nsub = bu ? 8/pb : (sz > pb ? sz/pb : 1);
    issue(1'b0, bu, sc, off, pc);
    chk("R2 read busy no oe", {62'b0, bus_busy_o, bus_data_oe_o}, 64'd2);
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < nsub; s++) begin
        v = {32'(tnum*1000 + b*10 + s), 32'hC0DE_0000 + 32'(b*8 + s)};
        bus_data_i = v;
        if (s < nsub-1) part_ack_i = 1'b1; else ack_i = 1'b1;
        @(negedge clk);
        part_ack_i = 1'b0; ack_i = 1'b0; bus_data_i = '0;
        chk("R10 rd valid", {63'b0, rd_valid_o}, 64'd1);
        chk("R10 rd data", rd_data_o, v);
        chk("R10 rd index", {59'b0, rd_beat_o, rd_sub_o}, 64'(b*8 + s));
      end
    end
    chk("R7 read release", {62'b0, bus_busy_o, xfer_done_o}, 64'd1);
    @(negedge clk);
    chk("R10 rd valid drops", {63'b0, rd_valid_o}, 64'd0);
  endtask

  task automatic do_abort(input bit wr, input bit use_retry);
    issue(wr, 1'b1, 3, 0, 3);
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    bus_data_i = 64'hDEAD_BEEF_0BAD_F00D;
    ack_i = 1'b1;
    if (use_retry) retry_i = 1'b1; else err_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0; retry_i = 1'b0; err_i = 1'b0;
    if (use_retry) begin
      chk("R9 retry release", {62'b0, bus_busy_o, bus_data_oe_o}, 64'd0);
      chk("R9 retry pulse", {61'b0, xfer_done_o, xfer_err_o, xfer_retry_o}, 64'd1);
      chk("R9 no rd beat", {63'b0, rd_valid_o}, 64'd0);
    end else begin
      chk("R8 err release", {62'b0, bus_busy_o, bus_data_oe_o}, 64'd0);
      chk("R8 err pulse", {61'b0, xfer_done_o, xfer_err_o, xfer_retry_o}, 64'd2);
      chk("R8 no rd beat", {63'b0, rd_valid_o}, 64'd0);
    end
    @(negedge clk);
    chk("R8 R9 pulses end", {61'b0, xfer_done_o, xfer_err_o, xfer_retry_o}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_start = 0; req_write = 0; req_burst = 0; req_size = 0; req_offset = 0;
    req_port = 0; req_wdata = '0; bus_data_i = '0;
    ack_i = 0; part_ack_i = 0; err_i = 0; retry_i = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {58'b0, bus_busy_o, bus_data_oe_o, xfer_done_o,
        xfer_err_o, xfer_retry_o, rd_valid_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {58'b0, bus_busy_o, bus_data_oe_o, xfer_done_o,
        xfer_err_o, xfer_retry_o, rd_valid_o}, 64'd0);

    for (int pc = 0; pc < 4; pc++) begin
      do_write(1'b1, 0, 0, pc, 1'b0);
      for (int sc = 0; sc < 4; sc++)
        for (int off = 0; off < 8; off += (1 << sc))
          do_write(1'b0, sc, off, pc, 1'b0);
    end
    do_write(1'b1, 0, 0, 1, 1'b1);

    for (int pc = 0; pc < 4; pc++) begin
      do_read(1'b1, 0, 0, pc);
      do_read(1'b0, 3, 0, pc);
      do_read(1'b0, 1, 6, pc);
    end

    do_abort(1'b1, 1'b0);
    do_abort(1'b0, 1'b0);
    do_abort(1'b1, 1'b1);
    do_abort(1'b0, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule